// File: doc/BRIEF.md
# Single-Wire Debug Bit Engine

This block is the target-side bit layer of a one-pin debug link. The link pin is pseudo-open-drain and shared by the host and the target. Every bit occupies a cell of 16 target bus clocks, and the host always opens a cell by pulling the pin low. The engine synchronizes the pin and detects the host's falling edge, then times the cell. In a host-to-target cell it samples the line partway through the cell to recover the bit. In a target-to-host cell it either stretches the low phase to send a zero, or drives a one-clock high pulse to send a one. That pulse gives the line a sharp rising edge in place of a slow resistor pull-up.

The engine gathers an 8-bit command after idle and presents it in parallel. The command decoder sits outside this block. Once the command has arrived, the decoder either hands the engine a 16-bit word to send or arms it to collect a 16-bit word. When the word is finished, the engine goes back to waiting for a command. All fields travel most significant bit first.

Top module: `wire_dbg_engine`

## Requirements
- R1: After reset, both pin drive enables, all three completion pulses, `cmd_o` and `rx_word_o` are 0, and the engine waits for a command.
- R2: A falling edge seen at the synchronized pin while no cell is running starts a cell of 16 clocks. Falling edges inside a running cell are ignored and do not restart or shift its timing.
- R3: In a host-to-target cell, the engine samples the synchronized line when the cell counter reads 10. A low level is a 0 and a high level is a 1.
- R4: In command mode, 8 cells form `cmd_o`, first bit in the MSB. `cmd_valid_o` is high for one clock, after clock edge 18 counted from the host pulling the pin low in the last cell.
- R5: With no cell running, `tx_load_i` captures `tx_word_i` and the next 16 cells send it, MSB first. `tx_done_o` pulses for one clock after edge 18 of the last cell.
- R6: A 0 bit is sent by asserting `pin_drv_lo_o` from clock edge 3 through edge 15 of the cell, counted from the host's low, which makes 13 consecutive clocks.
- R7: A 1 bit is sent by asserting `pin_drv_hi_o` for exactly one clock, after edge 10 of the cell, with `pin_drv_lo_o` kept at 0 for the whole cell.
- R8: With no cell running, `rx_arm_i` makes the next 16 host-to-target cells load `rx_word_o`, MSB first. `rx_valid_o` pulses for one clock after edge 18 of the last cell.
- R9: The two drive enables are never high together, and neither is ever high outside a cell that sends a bit.
- R10: `tx_load_i` and `rx_arm_i` have no effect while a cell is running. If both are high in the same idle clock, the load wins.
- R11: After a word completes in either direction, the following 8 cells are again taken as a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Target bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Raw level of the shared link pin |
| pin_drv_lo_o | output | 1 | Enable for the pull-down driver of the pin |
| pin_drv_hi_o | output | 1 | Enable for the short high speedup driver of the pin |
| cmd_o | output | 8 | Last received command byte |
| cmd_valid_o | output | 1 | One-clock pulse when a command byte is complete |
| rx_word_o | output | 16 | Last received data word |
| rx_valid_o | output | 1 | One-clock pulse when a data word is complete |
| tx_word_i | input | 16 | Word to send to the host |
| tx_load_i | input | 1 | Capture `tx_word_i` and enter send mode (idle only) |
| rx_arm_i | input | 1 | Enter word-receive mode (idle only) |
| tx_done_o | output | 1 | One-clock pulse when a sent word is finished |

## Verification
All timing is counted in rising clock edges after the host pulls the pin low, which happens just before edge 1. The synchronizer and the cell register put the start of the zero-stretch at edge 3, the end at edge 15, the speedup pulse at edge 10, and every completion pulse and parallel value at edge 18. The bench drives the pin and the control inputs on falling clock edges. On each falling edge it compares both drive enables and all three pulses with a behavioural reference, so each result is checked in the exact cycle it is due and is expected low in every other cycle. The host's own reading of a target bit is taken from the wired line at the falling edge after edge 10, in the same way as a real host.

// File: rtl/wire_dbg_pkg.sv
package wire_dbg_pkg;

    // Which way the next cells go.
    typedef enum logic [1:0] {
        MODE_CMD = 2'd0,
        MODE_RX  = 2'd1,
        MODE_TX  = 2'd2
    } link_mode_e;

endpackage

// File: rtl/wire_dbg_sync.sv
// Multi-stage synchronizer for the raw pin, plus a falling-edge strobe.
module wire_dbg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o,
    output logic fall_o
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              prev;
    } sync_t;

    sync_t q, d;
    logic [STAGES-1:0] nxt;

    assign nxt[0] = pin_i;
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        assign nxt[g] = q.sh[g-1];
    end

    assign level_o = q.sh[STAGES-1];
    assign fall_o  = q.prev & ~q.sh[STAGES-1];

    always_comb begin
        d      = q;
        d.sh   = nxt;
        d.prev = q.sh[STAGES-1];
    end

    // Idle line reads high.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end
endmodule

// File: rtl/wire_dbg_timer.sv
// Times one bit cell. An edge is accepted only while idle.
module wire_dbg_timer #(
    parameter int CELL_LEN = 16,
    parameter int CW       = $clog2(CELL_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fall_i,
    output logic          active_o,
    output logic [CW-1:0] cnt_o,
    output logic          start_o,
    output logic          end_o
);
    localparam logic [CW-1:0] LAST = CW'(CELL_LEN - 1);

    typedef struct packed {
        logic          active;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t q, d;

    assign active_o = q.active;
    assign cnt_o    = q.cnt;
    assign start_o  = fall_i & ~q.active;
    assign end_o    = q.active & (q.cnt == LAST);

    always_comb begin
        d = q;
        if (start_o) begin
            d.active = 1'b1;
            d.cnt    = CW'(1);
        end else if (end_o) begin
            d.active = 1'b0;
            d.cnt    = '0;
        end else if (q.active) begin
            d.cnt = q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/wire_dbg_drive.sv
// Produces the registered pin drive enables for a target-to-host bit.
module wire_dbg_drive #(
    parameter int ZERO_LOW = 13,
    parameter int PULSE_AT = 8,
    parameter int CW       = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          active_i,
    input  logic [CW-1:0] cnt_i,
    input  logic          tx_en_i,
    input  logic          tx_bit_i,
    output logic          drv_lo_o,
    output logic          drv_hi_o
);
    localparam logic [CW-1:0] LO_STOP = CW'(ZERO_LOW);
    localparam logic [CW-1:0] HI_PRE  = CW'(PULSE_AT - 1);

    typedef struct packed {
        logic lo;
        logic hi;
    } drv_t;

    drv_t q, d;

    assign drv_lo_o = q.lo;
    assign drv_hi_o = q.hi;

    always_comb begin
        d    = '0;
        // Low from the first cell count through ZERO_LOW.
        d.lo = tx_en_i & ~tx_bit_i &
               (start_i | (active_i & (cnt_i < LO_STOP)));
        // One clock high when the counter reads PULSE_AT.
        d.hi = tx_en_i & tx_bit_i & active_i & (cnt_i == HI_PRE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/wire_dbg_shift.sv
// Mode control, bit counting and the shift registers for both directions.
module wire_dbg_shift
    import wire_dbg_pkg::*;
#(
    parameter int CMD_BITS  = 8,
    parameter int WORD_BITS = 16,
    parameter int SAMPLE_AT = 10,
    parameter int CW        = 4,
    parameter int BW        = $clog2(WORD_BITS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 active_i,
    input  logic [CW-1:0]        cnt_i,
    input  logic                 end_i,
    input  logic                 level_i,
    input  logic                 tx_load_i,
    input  logic [WORD_BITS-1:0] tx_word_i,
    input  logic                 rx_arm_i,
    output link_mode_e           mode_o,
    output logic                 tx_bit_o,
    output logic [CMD_BITS-1:0]  cmd_o,
    output logic                 cmd_valid_o,
    output logic [WORD_BITS-1:0] rx_word_o,
    output logic                 rx_valid_o,
    output logic                 tx_done_o
);
    localparam logic [BW-1:0] CLAST = BW'(CMD_BITS - 1);
    localparam logic [BW-1:0] WLAST = BW'(WORD_BITS - 1);
    localparam logic [CW-1:0] SAMP  = CW'(SAMPLE_AT);

    typedef struct packed {
        link_mode_e           mode;
        logic [BW-1:0]        bitn;
        logic                 samp;
        logic [WORD_BITS-1:0] rx_sh;
        logic [WORD_BITS-1:0] tx_sh;
        logic [CMD_BITS-1:0]  cmd;
        logic                 cmd_vld;
        logic [WORD_BITS-1:0] rx_word;
        logic                 rx_vld;
        logic                 tx_done;
    } shf_t;

    shf_t q, d;

    assign mode_o      = q.mode;
    assign tx_bit_o    = q.tx_sh[WORD_BITS-1];
    assign cmd_o       = q.cmd;
    assign cmd_valid_o = q.cmd_vld;
    assign rx_word_o   = q.rx_word;
    assign rx_valid_o  = q.rx_vld;
    assign tx_done_o   = q.tx_done;

    always_comb begin
        logic [WORD_BITS-1:0] shifted;
        shifted   = {q.rx_sh[WORD_BITS-2:0], q.samp};
        d         = q;
        d.cmd_vld = 1'b0;
        d.rx_vld  = 1'b0;
        d.tx_done = 1'b0;

        if (active_i && (cnt_i == SAMP)) begin
            d.samp = level_i;
        end

        if (!active_i) begin
            if (tx_load_i) begin
                d.mode  = MODE_TX;
                d.tx_sh = tx_word_i;
                d.bitn  = '0;
            end else if (rx_arm_i) begin
                d.mode = MODE_RX;
                d.bitn = '0;
            end
        end

        if (end_i) begin
            unique case (q.mode)
                MODE_TX: begin
                    d.tx_sh = q.tx_sh << 1;
                    if (q.bitn == WLAST) begin
                        d.tx_done = 1'b1;
                        d.mode    = MODE_CMD;
                        d.bitn    = '0;
                    end else begin
                        d.bitn = q.bitn + BW'(1);
                    end
                end
                MODE_RX: begin
                    d.rx_sh = shifted;
                    if (q.bitn == WLAST) begin
                        d.rx_word = shifted;
                        d.rx_vld  = 1'b1;
                        d.mode    = MODE_CMD;
                        d.bitn    = '0;
                    end else begin
                        d.bitn = q.bitn + BW'(1);
                    end
                end
                default: begin
                    d.rx_sh = shifted;
                    if (q.bitn == CLAST) begin
                        d.cmd     = shifted[CMD_BITS-1:0];
                        d.cmd_vld = 1'b1;
                        d.bitn    = '0;
                    end else begin
                        d.bitn = q.bitn + BW'(1);
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/wire_dbg_engine.sv
// Target-side bit engine for a single-pin pseudo-open-drain debug link.
module wire_dbg_engine
    import wire_dbg_pkg::*;
#(
    parameter int CELL_LEN    = 16,
    parameter int SYNC_STAGES = 2,
    parameter int SAMPLE_AT   = 10,
    parameter int PULSE_AT    = 8,
    parameter int ZERO_LOW    = 13,
    parameter int CMD_BITS    = 8,
    parameter int WORD_BITS   = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pin_i,
    output logic                 pin_drv_lo_o,
    output logic                 pin_drv_hi_o,
    output logic [CMD_BITS-1:0]  cmd_o,
    output logic                 cmd_valid_o,
    output logic [WORD_BITS-1:0] rx_word_o,
    output logic                 rx_valid_o,
    input  logic [WORD_BITS-1:0] tx_word_i,
    input  logic                 tx_load_i,
    input  logic                 rx_arm_i,
    output logic                 tx_done_o
);
    localparam int CW = $clog2(CELL_LEN);
    localparam int BW = $clog2(WORD_BITS + 1);

    logic          level, fall;
    logic          active, start, cell_end;
    logic [CW-1:0] cnt;
    link_mode_e    mode;
    logic          tx_bit;
    logic [1:0]    link_mode;

    assign link_mode = mode;

    wire_dbg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (pin_i),
        .level_o (level),
        .fall_o  (fall)
    );

    wire_dbg_timer #(.CELL_LEN(CELL_LEN), .CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .fall_i   (fall),
        .active_o (active),
        .cnt_o    (cnt),
        .start_o  (start),
        .end_o    (cell_end)
    );

    wire_dbg_shift #(
        .CMD_BITS  (CMD_BITS),
        .WORD_BITS (WORD_BITS),
        .SAMPLE_AT (SAMPLE_AT),
        .CW        (CW),
        .BW        (BW)
    ) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .active_i    (active),
        .cnt_i       (cnt),
        .end_i       (cell_end),
        .level_i     (level),
        .tx_load_i   (tx_load_i),
        .tx_word_i   (tx_word_i),
        .rx_arm_i    (rx_arm_i),
        .mode_o      (mode),
        .tx_bit_o    (tx_bit),
        .cmd_o       (cmd_o),
        .cmd_valid_o (cmd_valid_o),
        .rx_word_o   (rx_word_o),
        .rx_valid_o  (rx_valid_o),
        .tx_done_o   (tx_done_o)
    );

    wire_dbg_drive #(
        .ZERO_LOW (ZERO_LOW),
        .PULSE_AT (PULSE_AT),
        .CW       (CW)
    ) u_drive (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .active_i (active),
        .cnt_i    (cnt),
        .tx_en_i  (mode == MODE_TX),
        .tx_bit_i (tx_bit),
        .drv_lo_o (pin_drv_lo_o),
        .drv_hi_o (pin_drv_hi_o)
    );
endmodule

// File: rtl/wire_dbg_engine_chk.sv
// Property checker, bound into the engine.
module wire_dbg_engine_chk #(
    parameter int ZERO_LOW = 13
) (
    input logic       clk,
    input logic       rst_n,
    input logic       drv_lo,
    input logic       drv_hi,
    input logic       cmd_valid,
    input logic       rx_valid,
    input logic       tx_done,
    input logic [1:0] mode
);
    int run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      run_q <= 0;
        else if (drv_lo) run_q <= run_q + 1;
        else             run_q <= 0;
    end

    a_r9_no_dual_drive: assert property (@(posedge clk) disable iff (!rst_n)
        !(drv_lo && drv_hi));

    a_r9_drive_only_tx: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_lo || drv_hi) |-> (mode == 2'd2));

    a_r7_one_clock_high: assert property (@(posedge clk) disable iff (!rst_n)
        drv_hi |=> !drv_hi);

    a_r6_low_stretch: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drv_lo) |-> (run_q == ZERO_LOW));

    a_r4_cmd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    a_r8_rx_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> !tx_done);

    a_r11_word_ends_in_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid || tx_done) |-> (mode == 2'd0));
endmodule

bind wire_dbg_engine wire_dbg_engine_chk #(.ZERO_LOW(ZERO_LOW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .drv_lo    (pin_drv_lo_o),
    .drv_hi    (pin_drv_hi_o),
    .cmd_valid (cmd_valid_o),
    .rx_valid  (rx_valid_o),
    .tx_done   (tx_done_o),
    .mode      (link_mode)
);

// File: tb/wire_dbg_engine_test.sv
module wire_dbg_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_low = 1'b0;
    logic [15:0] tx_word = '0;
    logic        tx_load = 1'b0;
    logic        rx_arm = 1'b0;
    wire         drv_lo, drv_hi, cmd_valid, rx_valid, tx_done;
    wire  [7:0]  cmd;
    wire  [15:0] rx_word;
    wire         pin_line = ~(host_low | drv_lo);

    int total = 0;
    int fails = 0;
    bit finished = 0;

    // Behavioural reference state: 0 command, 1 receive word, 2 send word.
    int          ref_mode = 0;
    int          ref_bits = 0;
    logic [15:0] ref_tx = '0;
    logic [15:0] ref_acc = '0;
    string       val_tag = "R4";
    string       tx_tag = "R5";

    always #5 clk = ~clk;

    wire_dbg_engine uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .pin_i        (pin_line),
        .pin_drv_lo_o (drv_lo),
        .pin_drv_hi_o (drv_hi),
        .cmd_o        (cmd),
        .cmd_valid_o  (cmd_valid),
        .rx_word_o    (rx_word),
        .rx_valid_o   (rx_valid),
        .tx_word_i    (tx_word),
        .tx_load_i    (tx_load),
        .rx_arm_i     (rx_arm),
        .tx_done_o    (tx_done)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // One bit cell, entered and left on a falling clock edge with the line idle.
    task automatic run_cell(input logic hb, input bit glitch, input bit inject);
        bit          reading = (ref_mode == 2);
        logic        exp_bit = reading ? ref_tx[15 - ref_bits] : hb;
        bit          last = (ref_bits == ((ref_mode == 0) ? 7 : 15));
        logic [15:0] acc_n = {ref_acc[14:0], hb};
        string       drv_tag = inject ? "R10" : (reading ? "R6" : "R9");
        host_low = 1'b1;
        for (int i = 1; i <= 18; i++) begin
            @(negedge clk);
            check(reading && !exp_bit ? "R6" : drv_tag, 16'(drv_lo),
                  16'(reading && !exp_bit && i >= 3 && i <= 15));
            check(reading && exp_bit ? "R7" : drv_tag, 16'(drv_hi),
                  16'(reading && exp_bit && i == 10));
            check(val_tag, 16'(cmd_valid), 16'(i == 18 && last && ref_mode == 0));
            check("R8", 16'(rx_valid), 16'(i == 18 && last && ref_mode == 1));
            check("R5", 16'(tx_done), 16'(i == 18 && last && ref_mode == 2));
            if (i == 18 && last && ref_mode == 0) check(val_tag, 16'(cmd), {8'h00, acc_n[7:0]});
            if (i == 18 && last && ref_mode == 1) check("R8", rx_word, acc_n);
            if (reading && i == 10) check(tx_tag, 16'(pin_line), 16'(exp_bit));
            if (!reading) begin
                if (!hb && i == 13) host_low = 1'b0;
                if (hb && i == 3) host_low = 1'b0;
                if (glitch && hb && i == 6) host_low = 1'b1;
                if (glitch && hb && i == 8) host_low = 1'b0;
            end else if (i == 3) begin
                host_low = 1'b0;
            end
            if (inject && i == 8) begin tx_load = 1'b1; tx_word = 16'hFFFF; end
            if (inject && i == 9) tx_load = 1'b0;
        end
        if (!reading) ref_acc = acc_n;
        if (last) begin ref_mode = 0; ref_bits = 0; end
        else ref_bits++;
    endtask

    task automatic send_cmd(input logic [7:0] c, input int glitch_at, input int inject_at);
        for (int b = 0; b < 8; b++)
            run_cell(c[7 - b], b == glitch_at, b == inject_at);
    endtask

    task automatic send_word(input logic [15:0] w);
        for (int b = 0; b < 16; b++) run_cell(w[15 - b], 1'b0, 1'b0);
    endtask

    task automatic read_word();
        for (int b = 0; b < 16; b++) run_cell(1'b0, 1'b0, 1'b0);
    endtask

    task automatic control(input bit ld, input bit arm, input logic [15:0] w);
        tx_load = ld; rx_arm = arm; tx_word = w;
        @(negedge clk);
        tx_load = 1'b0; rx_arm = 1'b0;
        if (ld) begin ref_mode = 2; ref_tx = w; ref_bits = 0; end
        else if (arm) begin ref_mode = 1; ref_bits = 0; end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: quiet outputs straight after reset
        check("R1", 16'(drv_lo), 16'd0);
        check("R1", 16'(drv_hi), 16'd0);
        check("R1", 16'(cmd_valid | rx_valid | tx_done), 16'd0);
        check("R1", 16'(cmd), 16'd0);
        check("R1", rx_word, 16'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R2, R3, R4: command with an extra falling edge inside a one-cell
        val_tag = "R2";
        send_cmd(8'hA5, 2, -1);
        val_tag = "R4";
        send_cmd(8'h3C, -1, -1);

        // R8: receive a word
        control(1'b0, 1'b1, 16'h0000);
        send_word(16'h96C3);

        // R11: back in command mode after a word
        val_tag = "R11";
        send_cmd(8'h5A, -1, -1);
        val_tag = "R4";

        // R5, R6, R7: send a word
        control(1'b1, 1'b0, 16'h8E31);
        read_word();

        // R10: load during a running cell has no effect
        val_tag = "R10";
        send_cmd(8'hFF, -1, 3);
        send_cmd(8'h00, -1, -1);

        // R10: load beats arm in the same clock
        control(1'b1, 1'b1, 16'h7001);
        tx_tag = "R10";
        read_word();
        tx_tag = "R5";
        val_tag = "R11";
        send_cmd(8'h81, -1, -1);

        repeat (4) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule